// File: doc/BRIEF.md
# Incremental Line-Stepping Engine

This block steps a pair of 12-bit pixel coordinates along a straight line using integer error arithmetic. Software first loads the start position, an initial error value, the long-axis length, the short-axis length and a 4-bit direction code through a small write port. It then issues an execute command with one of four operation modes. The engine runs a fixed twelve-cycle timing loop once per line step. On each step it updates the error register through a shared adder, decides from the stored adder carry whether the short axis moves, requests a pixel write, and moves the coordinate counters.

The short-axis length is stored in ones' complement form. The adder forces its carry-in high when it adds that operand, so the addition acts as a subtraction. The carry-out of that first addition is latched. When it is clear, a second error load adds the long-axis length back and the short axis steps. When it is set, that step has only the one error load. Pixel combining and memory timing sit outside the block: it only presents the write request together with the current X and Y.

Top module: `vse_engine`

## Requirements
- R1: After a synchronous reset, X, Y and the error register read 0; busy, done, pix_wr and erase_act are low; phase_code reads 0xC.
- R2: While busy, phase_code advances once per clock through 0xC, 0x3, 0x2, 0x1, 0x0, 0x5, 0x4, 0xB, 0xA, 0x9, 0x8, 0xD and then repeats. It reads 0xC in the first busy cycle.
- R3: When idle, a cfg_we write with cfg_sel 0 loads X, 1 loads Y, 2 loads the error register, 3 loads the long-axis length, 4 loads the short-axis length (ones' complement), and 5 loads the direction code from cfg_data[3:0]. X, Y and the error register show the new value in the next cycle. Writes while busy, and writes with cfg_sel 6 or 7, change nothing.
- R4: In each move step of a move or vector operation, the error register first becomes err + stored_short + 1, taken modulo 4096. The carry out of bit 11 is latched.
- R5: If that latched carry is clear, a second load adds the long-axis length to the error register, modulo 4096. If it is set, no second load occurs.
- R6: Direction code bit 0 set makes X count down, and bit 1 set makes Y count down; a clear bit counts up. Bit 2 set makes Y the long axis; clear makes X the long axis. The long axis moves by one on every move step. The short axis moves only when the latched carry is clear and bit 3 is clear. Coordinates wrap modulo 4096.
- R7: A move or vector operation with long-axis length L runs L+1 steps, of which the first L are move steps. done pulses high for one cycle, in the same cycle that busy falls, 12*(L+1)+1 cycles after the execute is accepted.
- R8: Vector mode (exec_mode 2) raises pix_wr for one cycle per step. It does so while X and Y still hold that step's point, before the move, so the start point and the end point are both written.
- R9: Move mode (exec_mode 0) follows the same coordinate and error path as vector mode and never raises pix_wr.
- R10: Dot mode (exec_mode 1) runs a single step with exactly one pix_wr at the unchanged X and Y. done appears 13 cycles after the execute is accepted.
- R11: Erase mode (exec_mode 3) holds erase_act high for exactly the busy cycles. It runs L+1 steps, never raises pix_wr, and leaves X, Y and the error register unchanged.
- R12: An execute request made while busy is ignored; the running operation keeps its length and no second operation follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 3 | Register select for the write |
| cfg_data | input | 12 | Write data |
| exec_req | input | 1 | Start an operation (accepted when idle) |
| exec_mode | input | 2 | 0 move, 1 dot, 2 vector, 3 erase |
| x_pos | output | 12 | Current X coordinate |
| y_pos | output | 12 | Current Y coordinate |
| err_val | output | 12 | Current error register |
| phase_code | output | 4 | Current timing phase code |
| busy | output | 1 | Operation in progress |
| pix_wr | output | 1 | One-cycle pixel write request at x_pos, y_pos |
| erase_act | output | 1 | Screen-clear operation in progress |
| done | output | 1 | One-cycle completion pulse |

## Verification
The first vector runs on a shallow X-major line. It exercises both the one-load and the two-load error paths, and it checks the full phase order. A second line is Y-major, counts down on both axes and wraps X through zero. This separates the axis-swap and direction bits from the carry logic. A third run sets the short-axis freeze bit, so only the long axis moves. Move, dot and erase runs reuse starting points whose outcomes are known. They separate write suppression, single-step termination and a frozen position. A register write and an execute request placed mid-run show that the busy state blocks both.

// File: rtl/vse_pkg.sv
package vse_pkg;
  localparam int unsigned PHASES = 12;
  localparam int unsigned DIR_W  = 4;

  typedef enum logic [1:0] {
    MD_MOVE  = 2'd0,
    MD_DOT   = 2'd1,
    MD_VEC   = 2'd2,
    MD_ERASE = 2'd3
  } mode_e;

  typedef enum logic [2:0] {
    SEL_X   = 3'd0,
    SEL_Y   = 3'd1,
    SEL_ERR = 3'd2,
    SEL_MAJ = 3'd3,
    SEL_MIN = 3'd4,
    SEL_DIR = 3'd5
  } sel_e;

  typedef struct packed {
    logic en_x;
    logic en_y;
    logic dn_x;
    logic dn_y;
    logic wr;
  } steer_t;

  // non-sequential sync order, indexed by loop position
  function automatic logic [3:0] phase_of(input logic [3:0] idx);
    case (idx)
      4'd0:    phase_of = 4'hC;
      4'd1:    phase_of = 4'h3;
      4'd2:    phase_of = 4'h2;
      4'd3:    phase_of = 4'h1;
      4'd4:    phase_of = 4'h0;
      4'd5:    phase_of = 4'h5;
      4'd6:    phase_of = 4'h4;
      4'd7:    phase_of = 4'hB;
      4'd8:    phase_of = 4'hA;
      4'd9:    phase_of = 4'h9;
      4'd10:   phase_of = 4'h8;
      default: phase_of = 4'hD;
    endcase
  endfunction
endpackage

// File: rtl/vse_seq.sv
module vse_seq #(
  parameter int unsigned N = 12
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 start,
  input  logic                 run,
  output logic [$clog2(N)-1:0] pos,
  output logic                 at_last
);
  localparam int unsigned PW = $clog2(N);
  localparam logic [PW-1:0] LAST = PW'(N - 1);

  assign at_last = (pos == LAST);

  always_ff @(posedge clk) begin
    if (rst || start) pos <= '0;
    else if (run)     pos <= at_last ? '0 : pos + 1'b1;
  end
endmodule

// File: rtl/vse_axis.sv
module vse_axis #(
  parameter int unsigned W = 12
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         step,
  input  logic         down,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst)       q <= '0;
    else if (load) q <= load_val;
    else if (step) q <= down ? q - 1'b1 : q + 1'b1;
  end
endmodule

// File: rtl/vse_dir_dec.sv
module vse_dir_dec
  import vse_pkg::*;
(
  input  logic [DIR_W-1:0] dir,
  input  logic             carry,
  input  logic             go,
  input  logic             wr_mode,
  output steer_t           steer
);
  logic y_major, minor_ok;

  always_comb begin
    y_major    = dir[2];
    minor_ok   = !dir[3] && !carry;
    steer.en_x = y_major ? minor_ok : 1'b1;
    steer.en_y = y_major ? 1'b1 : minor_ok;
    steer.dn_x = dir[0];
    steer.dn_y = dir[1];
    steer.wr   = go && wr_mode;
  end
endmodule

// File: rtl/vse_engine.sv
module vse_engine
  import vse_pkg::*;
#(
  parameter int unsigned W = 12
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         cfg_we,
  input  logic [2:0]   cfg_sel,
  input  logic [W-1:0] cfg_data,
  input  logic         exec_req,
  input  logic [1:0]   exec_mode,
  output logic [W-1:0] x_pos,
  output logic [W-1:0] y_pos,
  output logic [W-1:0] err_val,
  output logic [3:0]   phase_code,
  output logic         busy,
  output logic         pix_wr,
  output logic         erase_act,
  output logic         done
);
  localparam int unsigned PW = $clog2(PHASES);
  localparam logic [PW-1:0] POS_SUB  = PW'(1);
  localparam logic [PW-1:0] POS_ADD  = PW'(3);
  localparam logic [PW-1:0] POS_WR   = PW'(4);
  localparam logic [PW-1:0] POS_MOVE = PW'(6);

  logic [W-1:0]     err_q, maj_q, min_q, cnt_q;
  logic [DIR_W-1:0] dir_q;
  logic             carry_q, busy_q, end_q, done_q, pixwr_q, erase_q;
  mode_e            mode_q;

  logic [PW-1:0] pos;
  logic          at_last, run, start, cfg_ok, arith_on, wr_mode, step_now;
  logic [W:0]    sum_sub;
  logic [W-1:0]  sum_add;
  steer_t        steer;
  logic [1:0]    axis_ld, axis_step, axis_dn;
  logic [W-1:0]  axis_q [2];

  assign run      = busy_q && !end_q;
  assign start    = !busy_q && exec_req;
  assign cfg_ok   = cfg_we && !busy_q;
  assign arith_on = (mode_q == MD_VEC || mode_q == MD_MOVE) && (cnt_q != '0);
  assign wr_mode  = (mode_q == MD_VEC || mode_q == MD_DOT);
  assign sum_sub  = {1'b0, err_q} + {1'b0, min_q} + {{W{1'b0}}, 1'b1};
  assign sum_add  = err_q + maj_q;
  assign step_now = run && (pos == POS_MOVE) && arith_on;

  vse_seq #(.N(PHASES)) u_seq (
    .clk(clk), .rst(rst), .start(start), .run(run),
    .pos(pos), .at_last(at_last)
  );

  vse_dir_dec u_dec (
    .dir(dir_q), .carry(carry_q), .go(busy_q), .wr_mode(wr_mode), .steer(steer)
  );

  assign axis_ld   = {cfg_ok && cfg_sel == SEL_Y, cfg_ok && cfg_sel == SEL_X};
  assign axis_step = {steer.en_y, steer.en_x} & {2{step_now}};
  assign axis_dn   = {steer.dn_y, steer.dn_x};

  for (genvar g = 0; g < 2; g++) begin : g_axis
    vse_axis #(.W(W)) u_axis (
      .clk(clk), .rst(rst), .load(axis_ld[g]), .load_val(cfg_data),
      .step(axis_step[g]), .down(axis_dn[g]), .q(axis_q[g])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      err_q   <= '0;
      maj_q   <= '0;
      min_q   <= '0;
      cnt_q   <= '0;
      dir_q   <= '0;
      carry_q <= 1'b1;
      busy_q  <= 1'b0;
      end_q   <= 1'b0;
      done_q  <= 1'b0;
      pixwr_q <= 1'b0;
      erase_q <= 1'b0;
      mode_q  <= MD_MOVE;
    end else begin
      done_q  <= 1'b0;
      pixwr_q <= 1'b0;
      if (!busy_q) begin
        if (cfg_we) begin
          case (cfg_sel)
            SEL_ERR: err_q <= cfg_data;
            SEL_MAJ: maj_q <= cfg_data;
            SEL_MIN: min_q <= cfg_data;
            SEL_DIR: dir_q <= cfg_data[DIR_W-1:0];
            default: ;
          endcase
        end
        if (exec_req) begin
          busy_q  <= 1'b1;
          mode_q  <= mode_e'(exec_mode);
          cnt_q   <= (mode_e'(exec_mode) == MD_DOT) ? '0 : maj_q;
          carry_q <= 1'b1;
          erase_q <= (mode_e'(exec_mode) == MD_ERASE);
        end
      end else if (end_q) begin
        busy_q  <= 1'b0;
        end_q   <= 1'b0;
        done_q  <= 1'b1;
        erase_q <= 1'b0;
      end else begin
        if (pos == POS_SUB && arith_on) begin
          err_q   <= sum_sub[W-1:0];
          carry_q <= sum_sub[W];
        end
        if (pos == POS_ADD && arith_on && !carry_q) err_q <= sum_add;
        if (pos == POS_WR) pixwr_q <= steer.wr;
        if (at_last) begin
          if (cnt_q == '0) end_q <= 1'b1;
          else             cnt_q <= cnt_q - 1'b1;
        end
      end
    end
  end

  assign x_pos      = axis_q[0];
  assign y_pos      = axis_q[1];
  assign err_val    = err_q;
  assign phase_code = phase_of(4'(pos));
  assign busy       = busy_q;
  assign pix_wr     = pixwr_q;
  assign erase_act  = erase_q;
  assign done       = done_q;
endmodule

// File: rtl/vse_engine_chk.sv
module vse_engine_chk (
  input logic       clk,
  input logic       rst,
  input logic       busy,
  input logic       done,
  input logic       pix_wr,
  input logic       erase_act,
  input logic [3:0] phase_code
);
  assert_start_phase_R2: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> phase_code == 4'hC);

  assert_phase_order_R2: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy) && phase_code == 4'h3) |-> $past(phase_code) == 4'hC);

  assert_done_end_R7: assert property (@(posedge clk) disable iff (rst)
    done |-> (!busy && $past(busy)));

  assert_done_pulse_R7: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  assert_wr_busy_R8: assert property (@(posedge clk) disable iff (rst)
    pix_wr |-> busy);

  assert_erase_busy_R11: assert property (@(posedge clk) disable iff (rst)
    erase_act |-> busy);

  assert_erase_nowr_R11: assert property (@(posedge clk) disable iff (rst)
    erase_act |-> !pix_wr);
endmodule

bind vse_engine vse_engine_chk u_chk (.*);

// File: tb/vse_engine_tb.sv
module vse_engine_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_we = 1'b0;
  logic [2:0]  cfg_sel = '0;
  logic [11:0] cfg_data = '0;
  logic        exec_req = 1'b0;
  logic [1:0]  exec_mode = '0;
  logic [11:0] x_pos, y_pos, err_val;
  logic [3:0]  phase_code;
  logic        busy, pix_wr, erase_act, done;

  int total = 0;
  int bad = 0;

  int          npix = 0;
  int          nerase = 0;
  logic [11:0] px [64];
  logic [11:0] py [64];
  logic [11:0] ex [64];
  logic [11:0] ey [64];
  logic [3:0]  ph [24];
  int          en;
  logic [11:0] fx, fy, fe;

  always #5 clk = ~clk;

  vse_engine dut_i (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_data(cfg_data),
    .exec_req(exec_req), .exec_mode(exec_mode), .x_pos(x_pos), .y_pos(y_pos),
    .err_val(err_val), .phase_code(phase_code), .busy(busy), .pix_wr(pix_wr),
    .erase_act(erase_act), .done(done)
  );

  always @(negedge clk) begin
    if (!rst && pix_wr) begin
      if (npix < 64) begin
        px[npix] = x_pos;
        py[npix] = y_pos;
      end
      npix = npix + 1;
    end
    if (!rst && erase_act) nerase = nerase + 1;
  end

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [2:0] s, input logic [11:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = s; cfg_data = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic setup(input logic [11:0] x0, input logic [11:0] y0, input logic [11:0] e0,
                       input logic [11:0] maj, input logic [11:0] mn, input logic [3:0] dir);
    wr_reg(3'd0, x0);
    wr_reg(3'd1, y0);
    wr_reg(3'd2, e0);
    wr_reg(3'd3, maj);
    wr_reg(3'd4, ~mn);
    wr_reg(3'd5, {8'd0, dir});
  endtask

  // expected line from the requirement arithmetic
  task automatic model(input logic [11:0] x0, input logic [11:0] y0, input logic [11:0] e0,
                       input logic [11:0] maj, input logic [11:0] mn, input logic [3:0] dir);
    logic [12:0] t;
    logic [11:0] x, y, e;
    logic        c;
    x = x0; y = y0; e = e0; en = 0;
    for (int s = 0; s <= int'(maj); s++) begin
      if (en < 64) begin ex[en] = x; ey[en] = y; end
      en++;
      if (s < int'(maj)) begin
        t = {1'b0, e} + {1'b0, ~mn} + 13'd1;
        c = t[12];
        e = t[11:0];
        if (!c) e = e + maj;
        if (dir[2]) begin
          y = dir[1] ? y - 1'b1 : y + 1'b1;
          if (!c && !dir[3]) x = dir[0] ? x - 1'b1 : x + 1'b1;
        end else begin
          x = dir[0] ? x - 1'b1 : x + 1'b1;
          if (!c && !dir[3]) y = dir[1] ? y - 1'b1 : y + 1'b1;
        end
      end
    end
    fx = x; fy = y; fe = e;
  endtask

  task automatic run_exec(input logic [1:0] m, input bit poke, output int cyc);
    npix = 0;
    nerase = 0;
    @(negedge clk);
    exec_req = 1'b1; exec_mode = m;
    @(negedge clk);
    exec_req = 1'b0;
    cyc = 0;
    while (!done && cyc < 5000) begin
      if (cyc < 24) ph[cyc] = phase_code;
      if (poke && cyc == 20) begin
        cfg_we = 1'b1; cfg_sel = 3'd0; cfg_data = 12'hABC;
        exec_req = 1'b1; exec_mode = 2'd3;
      end
      if (poke && cyc == 21) begin
        cfg_we = 1'b0; exec_req = 1'b0;
      end
      @(negedge clk);
      cyc++;
    end
    chk("R7 busy low with done", int'(busy), 0);
    @(negedge clk);
    chk("R7 done one cycle", int'(done), 0);
    chk("R12 no second run", int'(busy), 0);
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk("R1 x", int'(x_pos), 0);
    chk("R1 y", int'(y_pos), 0);
    chk("R1 err", int'(err_val), 0);
    chk("R1 flags", int'({busy, done, pix_wr, erase_act}), 0);
    chk("R1 phase", int'(phase_code), 12);
  endtask

  task automatic t_cfg();
    wr_reg(3'd0, 12'h123);
    chk("R3 x load", int'(x_pos), 12'h123);
    wr_reg(3'd1, 12'h456);
    chk("R3 y load", int'(y_pos), 12'h456);
    wr_reg(3'd2, 12'h789);
    chk("R3 err load", int'(err_val), 12'h789);
    wr_reg(3'd6, 12'hFFF);
    wr_reg(3'd7, 12'h000);
    chk("R3 unused sel x", int'(x_pos), 12'h123);
    chk("R3 unused sel y", int'(y_pos), 12'h456);
    chk("R3 unused sel err", int'(err_val), 12'h789);
  endtask

  task automatic t_line(input string tag, input logic [1:0] m, input bit poke,
                        input logic [11:0] x0, input logic [11:0] y0, input logic [11:0] e0,
                        input logic [11:0] maj, input logic [11:0] mn, input logic [3:0] dir);
    int cyc;
    logic [3:0] seq [12] = '{4'hC, 4'h3, 4'h2, 4'h1, 4'h0, 4'h5, 4'h4,
                             4'hB, 4'hA, 4'h9, 4'h8, 4'hD};
    setup(x0, y0, e0, maj, mn, dir);
    model(x0, y0, e0, maj, mn, dir);
    run_exec(m, poke, cyc);
    chk({tag, " R7 duration"}, cyc, 12 * (int'(maj) + 1) + 1);
    chk({tag, " R6 final x"}, int'(x_pos), int'(fx));
    chk({tag, " R6 final y"}, int'(y_pos), int'(fy));
    chk({tag, " R4 R5 final err"}, int'(err_val), int'(fe));
    if (poke) begin
      for (int k = 0; k < 24; k++) chk("R2 phase order", int'(ph[k]), int'(seq[k % 12]));
    end
    if (m == 2'd2) begin
      chk({tag, " R8 write count"}, npix, en);
      for (int k = 0; k < en && k < 64; k++) begin
        chk({tag, " R8 pixel x"}, int'(px[k]), int'(ex[k]));
        chk({tag, " R8 pixel y"}, int'(py[k]), int'(ey[k]));
      end
    end else begin
      chk({tag, " R9 no writes in move"}, npix, 0);
    end
  endtask

  task automatic t_dot();
    int cyc;
    setup(12'd300, 12'd400, 12'd9, 12'd7, 12'd3, 4'd0);
    run_exec(2'd1, 1'b0, cyc);
    chk("R10 duration", cyc, 13);
    chk("R10 one write", npix, 1);
    chk("R10 write x", int'(px[0]), 300);
    chk("R10 write y", int'(py[0]), 400);
    chk("R10 x kept", int'(x_pos), 300);
    chk("R10 err kept", int'(err_val), 9);
  endtask

  task automatic t_erase();
    int cyc;
    setup(12'h010, 12'h020, 12'd7, 12'd3, 12'd2, 4'd0);
    run_exec(2'd3, 1'b0, cyc);
    chk("R11 duration", cyc, 49);
    chk("R11 erase cycles", nerase, 49);
    chk("R11 no writes", npix, 0);
    chk("R11 x kept", int'(x_pos), 12'h010);
    chk("R11 y kept", int'(y_pos), 12'h020);
    chk("R11 err kept", int'(err_val), 7);
    chk("R11 erase dropped", int'(erase_act), 0);
  endtask

  initial begin
    #1000000;
    bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_cfg();
    // shallow X-major line, busy-time write and exec injected (R3, R12)
    t_line("vecA", 2'd2, 1'b1, 12'd10, 12'd20, 12'd2, 12'd5, 12'd2, 4'b0000);
    // Y-major, both axes down, X wraps through zero
    t_line("vecB", 2'd2, 1'b0, 12'd3, 12'd100, 12'd1, 12'd6, 12'd4, 4'b0111);
    // short axis frozen by direction bit 3
    t_line("vecC", 2'd2, 1'b0, 12'd50, 12'd60, 12'd0, 12'd4, 12'd5, 4'b1001);
    // move mode on the same path as vecA
    t_line("move", 2'd0, 1'b0, 12'd10, 12'd20, 12'd2, 12'd5, 12'd2, 4'b0000);
    t_dot();
    t_erase();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule